// File: doc/BRIEF.md
# Configurable Macrocell Register Cell

This block is one programmable storage cell of the kind found in small programmable logic devices. A set of static configuration inputs picks how the cell stores its data input: as a D, T, JK or SR flip-flop. The cell can also skip storage entirely and pass its data input straight to the output. The same configuration picks which edge the cell updates on. It can follow one of the global clock inputs in true or inverted polarity, follow that global clock only when a logic-generated enable is high, or follow a clock generated by the logic array itself.

All sources are sampled on the fabric clock `clk`. An update happens on the fabric cycle in which the selected source, after its polarity is applied, is first seen high. The logic-driven preset, the logic-driven clear and the device-wide active-low clear act on the output at once, in the same cycle and without an edge. The stored state also takes the forced value at the next fabric edge. The synchronous reset `rst` stands for power-up. It clears the storage register. The power-up level option stores the state inverted and inverts it again at the output, so a cell with that option comes up high.

Top module: `mc_cell`

## Requirements
- R1: One cycle after `rst` is sampled high, `q` equals `cfg_pu_high`, and it keeps that value until an active edge or a preset or clear arrives.
- R2: With `cfg_kind`=0 (D), each active edge loads `pt_a` into the state.
- R3: With `cfg_kind`=1 (T), an active edge inverts the state when `pt_a`=1 and leaves it unchanged when `pt_a`=0.
- R4: With `cfg_kind`=2 (JK, J=`pt_a`, K=`pt_b`), an active edge holds on 00, clears on 01, sets on 10 and toggles on 11.
- R5: With `cfg_kind`=3 (SR, S=`pt_a`, R=`pt_b`), an active edge holds on 00, clears on 01 and sets on 10, and 11 clears.
- R6: With `cfg_bypass`=1, `q` equals `pt_a` in the same cycle, and clock edges, preset and clear have no effect on `q`.
- R7: With `cfg_clk_mode`=0, the active edge is a rising edge of `gclk[cfg_gclk_sel]` XOR `cfg_gclk_inv`. Edges on the unselected global clock, and on `pt_clk`, are ignored.
- R8: With `cfg_clk_mode`=1, the edge rule of R7 applies only while `pt_en`=1. With `pt_en`=0 the state holds whatever the data inputs are.
- R9: With `cfg_clk_mode`=2, the active edge is a rising edge of `pt_clk`, and global clock edges are ignored.
- R10: `pt_preset`=1 drives `q` to 1 in the same cycle with no edge needed, and `q` stays 1 after the preset is released.
- R11: `pt_clear`=1 or `gclr_n`=0 drives `q` to 0 in the same cycle, and this wins over a preset that is asserted at the same time.
- R12: With `cfg_pu_high`=1, the cell behaves the same as with 0 once it leaves power-up: data edges, preset and clear give the same logical `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric sampling clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cfg_kind | input | 2 | Storage type: 0 D, 1 T, 2 JK, 3 SR |
| cfg_bypass | input | 1 | 1 routes `pt_a` straight to `q` |
| cfg_clk_mode | input | 2 | 0 global clock, 1 global clock with enable, 2 array clock (3 acts as 0) |
| cfg_gclk_sel | input | GSEL_W | Which global clock is used |
| cfg_gclk_inv | input | 1 | Inverts the selected global clock |
| cfg_pu_high | input | 1 | Power-up level of `q` |
| gclk | input | NUM_GCLK | Global clock inputs |
| pt_clk | input | 1 | Clock from the logic array |
| pt_en | input | 1 | Active-high clock enable from the logic array |
| pt_a | input | 1 | D, T, J or S data input |
| pt_b | input | 1 | K or R data input |
| pt_preset | input | 1 | Asynchronous preset, active high |
| pt_clear | input | 1 | Asynchronous clear, active high |
| gclr_n | input | 1 | Device-wide clear, active low |
| q | output | 1 | Cell output |

## Verification
The properties assume that the configuration inputs do not move while the cell runs. The stimulus meets this by changing them only in cycles where `pt_clear` is held high. They also assume that each level of a clock source lasts at least one fabric cycle, since an edge is only seen through sampling. The stimulus moves every clock source at most once per fabric cycle. The hold properties also assume that preset and clear stay low across the observed pair of cycles, and they exclude cycles in which they do not.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ff_kind_e;

  typedef enum logic [1:0] {
    CK_GLOBAL    = 2'd0,
    CK_GLOBAL_EN = 2'd1,
    CK_ARRAY     = 2'd2,
    CK_SPARE     = 2'd3
  } ck_mode_e;

endpackage

// File: rtl/mc_clk_select.sv
module mc_clk_select
  import mc_pkg::*;
#(
  parameter int NUM_GCLK = 2,
  localparam int GSEL_W  = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                clk,
  input  logic [1:0]          mode,
  input  logic [GSEL_W-1:0]   gsel,
  input  logic                ginv,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                pt_clk,
  input  logic                pt_en,
  output logic                fire
);

  ck_mode_e mode_e;
  logic     src_now;
  logic     src_prev;
  logic     gate;

  always_comb begin
    mode_e = ck_mode_e'(mode);
    if (mode_e == CK_ARRAY) src_now = pt_clk;
    else                    src_now = gclk[gsel] ^ ginv;
    gate = (mode_e == CK_GLOBAL_EN) ? pt_en : 1'b1;
    fire = src_now & ~src_prev & gate;
  end

  always_ff @(posedge clk) begin
    src_prev <= src_now;
  end

endmodule

// File: rtl/mc_next_logic.sv
module mc_next_logic
  import mc_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       cur,
  input  logic       a,
  input  logic       b,
  output logic       nxt
);

  always_comb begin
    unique case (ff_kind_e'(kind))
      FF_D:  nxt = a;
      FF_T:  nxt = cur ^ a;
      FF_JK: begin
        unique case ({a, b})
          2'b00:   nxt = cur;
          2'b01:   nxt = 1'b0;
          2'b10:   nxt = 1'b1;
          default: nxt = ~cur;
        endcase
      end
      default: begin
        unique case ({a, b})
          2'b00:   nxt = cur;
          2'b10:   nxt = 1'b1;
          default: nxt = 1'b0;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic clk,
  input  logic rst,
  input  logic pu_high,
  input  logic fire,
  input  logic nxt,
  input  logic set_req,
  input  logic clr_req,
  output logic state_q
);

  logic stor;

  always_ff @(posedge clk) begin
    if (rst)          stor <= 1'b0;
    else if (clr_req) stor <= pu_high;
    else if (set_req) stor <= ~pu_high;
    else if (fire)    stor <= nxt ^ pu_high;
  end

  assign state_q = stor ^ pu_high;

endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter int NUM_GCLK = 2,
  localparam int GSEL_W  = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_kind,
  input  logic                cfg_bypass,
  input  logic [1:0]          cfg_clk_mode,
  input  logic [GSEL_W-1:0]   cfg_gclk_sel,
  input  logic                cfg_gclk_inv,
  input  logic                cfg_pu_high,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                pt_clk,
  input  logic                pt_en,
  input  logic                pt_a,
  input  logic                pt_b,
  input  logic                pt_preset,
  input  logic                pt_clear,
  input  logic                gclr_n,
  output logic                q
);

  logic fire;
  logic nxt;
  logic state_q;
  logic clr_req;

  assign clr_req = pt_clear | ~gclr_n;

  mc_clk_select #(.NUM_GCLK(NUM_GCLK)) u_clk (
    .clk    (clk),
    .mode   (cfg_clk_mode),
    .gsel   (cfg_gclk_sel),
    .ginv   (cfg_gclk_inv),
    .gclk   (gclk),
    .pt_clk (pt_clk),
    .pt_en  (pt_en),
    .fire   (fire)
  );

  mc_next_logic u_next (
    .kind (cfg_kind),
    .cur  (state_q),
    .a    (pt_a),
    .b    (pt_b),
    .nxt  (nxt)
  );

  mc_store u_store (
    .clk     (clk),
    .rst     (rst),
    .pu_high (cfg_pu_high),
    .fire    (fire),
    .nxt     (nxt),
    .set_req (pt_preset),
    .clr_req (clr_req),
    .state_q (state_q)
  );

  always_comb begin
    if (cfg_bypass)     q = pt_a;
    else if (clr_req)   q = 1'b0;
    else if (pt_preset) q = 1'b1;
    else                q = state_q;
  end

endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_kind,
  input logic       cfg_bypass,
  input logic [1:0] cfg_clk_mode,
  input logic       cfg_pu_high,
  input logic       pt_en,
  input logic       pt_a,
  input logic       pt_preset,
  input logic       pt_clear,
  input logic       gclr_n,
  input logic       q
);

  logic quiet;
  assign quiet = !cfg_bypass && !pt_clear && gclr_n && !pt_preset;

  assert_powerup_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && quiet) |-> (q == cfg_pu_high));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_bypass |-> (q == pt_a));

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (!cfg_bypass && (pt_clear || !gclr_n)) |-> !q);

  assert_preset_R10: assert property (@(posedge clk) disable iff (rst)
    (!cfg_bypass && pt_preset && !pt_clear && gclr_n) |-> q);

  assert_enable_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (quiet && cfg_clk_mode == 2'd1 && !pt_en) |=> (!quiet || q == $past(q)));

  assert_t_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (quiet && cfg_kind == 2'd1 && !pt_a) |=> (!quiet || q == $past(q)));

endmodule

bind mc_cell mc_cell_chk u_chk (.*);

// File: tb/mc_cell_tb.sv
`timescale 1ns/1ps
module mc_cell_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_kind = 2'd0;
  logic       cfg_bypass = 1'b0;
  logic [1:0] cfg_clk_mode = 2'd0;
  logic       cfg_gclk_sel = 1'b0;
  logic       cfg_gclk_inv = 1'b0;
  logic       cfg_pu_high = 1'b0;
  logic [1:0] gclk = 2'b00;
  logic       pt_clk = 1'b0;
  logic       pt_en = 1'b0;
  logic       pt_a = 1'b0;
  logic       pt_b = 1'b0;
  logic       pt_preset = 1'b0;
  logic       pt_clear = 1'b0;
  logic       gclr_n = 1'b1;
  logic       q;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  logic m_lq = 1'b0;
  logic m_prev = 1'b0;

  always #4 clk = ~clk;

  mc_cell #(.NUM_GCLK(2)) u_dut (.*);

  function automatic logic next_val(logic [1:0] k, logic cur, logic a, logic b);
    case (k)
      2'd0: return a;
      2'd1: return a ? !cur : cur;
      2'd2: return (a && b) ? !cur : (a ? 1'b1 : (b ? 1'b0 : cur));
      default: return (a && !b) ? 1'b1 : ((!a && !b) ? cur : 1'b0);
    endcase
  endfunction

  function automatic logic expect_q();
    if (cfg_bypass) return pt_a;
    if (pt_clear || !gclr_n) return 1'b0;
    if (pt_preset) return 1'b1;
    return m_lq;
  endfunction

  task automatic compare();
    logic e;
    e = expect_q();
    n_run++;
    if (q !== e) begin
      n_fail++;
      $display("FAIL %s: q=%0b expected %0b at %0t", cur_req, q, e, $time);
    end
  endtask

  task automatic cycle();
    logic s;
    logic f;
    @(posedge clk);
    s = (cfg_clk_mode == 2'd2) ? pt_clk : (gclk[cfg_gclk_sel] ^ cfg_gclk_inv);
    f = s && !m_prev && (cfg_clk_mode != 2'd1 || pt_en);
    m_prev = s;
    if (rst) m_lq = cfg_pu_high;
    else if (pt_clear || !gclr_n) m_lq = 1'b0;
    else if (pt_preset) m_lq = 1'b1;
    else if (f) m_lq = next_val(cfg_kind, m_lq, pt_a, pt_b);
    #2;
    compare();
  endtask

  task automatic settle();
    #1;
    compare();
  endtask

  task automatic reconf(logic [1:0] k, logic [1:0] m, logic gs, logic gi, logic byp);
    pt_clear = 1'b1;
    cycle();
    cfg_kind = k; cfg_clk_mode = m; cfg_gclk_sel = gs;
    cfg_gclk_inv = gi; cfg_bypass = byp;
    cycle();
    pt_clear = 1'b0;
    cycle();
  endtask

  task automatic gpulse(int idx);
    gclk[idx] = ~gclk[idx]; cycle();
    gclk[idx] = ~gclk[idx]; cycle();
  endtask

  initial begin
    cur_req = "R1";
    cycle(); cycle();
    rst = 1'b0;
    cycle(); cycle();
    rst = 1'b1; cfg_pu_high = 1'b1;
    cycle();
    rst = 1'b0;
    cycle(); cycle();

    cur_req = "R12";
    pt_a = 1'b0; gpulse(0);
    pt_a = 1'b1; gpulse(0);
    pt_preset = 1'b1; settle(); cycle(); pt_preset = 1'b0; cycle();
    pt_clear = 1'b1; settle(); cycle(); pt_clear = 1'b0; cycle();
    pt_a = 1'b1; gpulse(0);
    pt_clear = 1'b1; cycle(); cfg_pu_high = 1'b0; cycle(); pt_clear = 1'b0; cycle();

    cur_req = "R2";
    reconf(2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin pt_a = (8'b0110_1101 >> i) & 1'b1; gpulse(0); end

    cur_req = "R3";
    reconf(2'd1, 2'd0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin pt_a = (i % 3) != 2; gpulse(0); end

    cur_req = "R4";
    reconf(2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      {pt_a, pt_b} = 2'((16'b00_10_11_11_01_11_10_00 >> (2 * i)) & 2'b11);
      gpulse(0);
    end

    cur_req = "R5";
    reconf(2'd3, 2'd0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      {pt_a, pt_b} = 2'((16'b11_10_00_11_10_01_00_10 >> (2 * i)) & 2'b11);
      gpulse(0);
    end

    cur_req = "R7";
    reconf(2'd0, 2'd0, 1'b1, 1'b1, 1'b0);
    pt_a = 1'b1; gpulse(0); pt_clk = 1'b1; cycle(); pt_clk = 1'b0; cycle();
    gpulse(1);
    pt_a = 1'b0; gclk[1] = 1'b1; cycle(); gclk[1] = 1'b0; cycle(); cycle();

    cur_req = "R8";
    reconf(2'd1, 2'd1, 1'b0, 1'b0, 1'b0);
    pt_en = 1'b0; pt_a = 1'b1; gpulse(0); gpulse(0);
    pt_en = 1'b1; gpulse(0); pt_a = 1'b0; gpulse(0);
    pt_a = 1'b1; gpulse(0); pt_en = 1'b0; gpulse(0);

    cur_req = "R9";
    reconf(2'd0, 2'd2, 1'b0, 1'b0, 1'b0);
    pt_a = 1'b1; gpulse(0); gpulse(1);
    pt_clk = 1'b1; cycle(); pt_clk = 1'b0; cycle();
    pt_a = 1'b0; pt_clk = 1'b1; cycle(); pt_clk = 1'b0; cycle();

    cur_req = "R10";
    pt_preset = 1'b1; settle(); cycle(); cycle();
    pt_preset = 1'b0; cycle(); cycle();

    cur_req = "R11";
    pt_preset = 1'b1; pt_clear = 1'b1; settle(); cycle();
    pt_clear = 1'b0; cycle(); gclr_n = 1'b0; settle(); cycle();
    pt_preset = 1'b0; cycle(); gclr_n = 1'b1; cycle(); cycle();

    cur_req = "R6";
    reconf(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      pt_a = i[0]; settle(); pt_preset = i[1]; pt_clear = i[2]; settle();
      gclk[0] = ~gclk[0]; cycle();
    end
    pt_preset = 1'b0; pt_clear = 1'b0;

    cur_req = "R4";
    for (int c = 0; c < 12; c++) begin
      logic [7:0] lf;
      reconf(2'(c), 2'(c / 4), 1'(c / 2), 1'(c / 3), 1'b0);
      lf = 8'hA5 + 8'(c);
      for (int i = 0; i < 40; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        pt_a = lf[0]; pt_b = lf[1]; pt_en = lf[2];
        gclk[lf[3]] = lf[4]; pt_clk = lf[5];
        cycle();
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule